// File: doc/BRIEF.md
# Frame-Synchronous Slice Scrambler

This block scrambles one device's share of an interleaved high-order line signal. Several identical devices each handle every N-th byte of the line, and each one must produce the bytes that a single bit-serial scrambler would produce at line rate. That serial scrambler has a period of 127 bits, uses the polynomial 1 + x^6 + x^7 and is reloaded with all ones at the start of every frame. Each device therefore generates only a decimated slice of that sequence. A size select chooses between a two-device (16-way) and an eight-device (64-way) interleave. A 3-bit position code tells the device which slice it owns.

One byte enters on every clock and the scrambled byte leaves one clock later. A frame-start strobe marks the first byte of a frame and loads the position-dependent starting state. An overhead flag marks bytes of the regenerator section overhead. These bytes pass through unchanged and do not advance the generator. An active-low enable switches the XOR on and off. Frame counting is done elsewhere.

Top module: `fsync_slice_scrambler`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, dout is 8'h00.
- R2: dout at each clock edge equals the din sampled at the previous edge, XORed with a key byte or with zero. When scr_en_n was high (scrambling off), the key byte is zero.
- R3: The key sequence is the serial sequence b[n] with b[0..6] = 1 and b[n] = b[n-6] XOR b[n-7]. Key byte k uses bits b[8k] to b[8k+7], and b[8k] goes to bit 7 (transmitted first).
- R4: A byte presented with frame_start high is scrambled with the key for the device's first line byte of a new frame, which is key byte pos_code.
- R5: size_sel = 0 selects a 16-way interleave (2 devices, 16 serial steps between own bytes). size_sel = 1 selects a 64-way interleave (8 devices, 64 steps).
- R6: A byte presented with in_oh high leaves unchanged, and the generator does not advance on it. The next non-overhead byte therefore uses the key that the overhead byte would have received.
- R7: If all positions of an interleave are placed side by side, their outputs equal the serial scrambler applied to the whole line. Overhead slots are excluded from the sequence.
- R8: The generator keeps advancing on non-overhead bytes while scr_en_n is high, so scrambling resumes in phase when it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scr_en_n | input | 1 | Scrambling enable, active low |
| frame_start | input | 1 | Marks the first byte of a frame |
| in_oh | input | 1 | Current byte is regenerator section overhead |
| size_sel | input | 1 | 0: 16-way interleave, 1: 64-way interleave |
| pos_code | input | 3 | Device position within the interleave, 0 is the master |
| din | input | 8 | Input byte |
| dout | output | 8 | Scrambled byte, one cycle after din |

## Verification
The hardest case to reach is a mix of overhead slots and disabled slots in the middle of a frame. An overhead slot freezes the generator, while a disabled slot advances it without applying the key. An error in either one only shows up in later bytes. The stimulus table covers this with per-slot overhead and disable masks, across several sizes and positions. Every byte is compared against a bit-serial sequence built from the recurrence, with the expected key index counted over the non-overhead slots of the whole interleaved line.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int LFSR_W    = 7;
  localparam int BYTE_W    = 8;
  localparam int SMALL_IL  = 2;
  localparam int LARGE_IL  = 8;
  localparam int POS_W     = 3;
  localparam int MAX_ADV   = BYTE_W * LARGE_IL;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam lfsr_t LFSR_ONES = '1;

  // one serial step of 1 + x^6 + x^7; the oldest bit sits at the top
  function automatic lfsr_t lfsr_next(input lfsr_t s);
    return {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
  endfunction

  // advance by n serial steps, n <= MAX_ADV
  function automatic lfsr_t lfsr_adv(input lfsr_t s, input int n);
    lfsr_t t = s;
    for (int i = 0; i < MAX_ADV; i++)
      if (i < n) t = lfsr_next(t);
    return t;
  endfunction

  // eight key bits from a state, the first serial bit in the MSB
  function automatic byte_t key_of(input lfsr_t s);
    byte_t k;
    lfsr_t t = s;
    for (int i = 0; i < BYTE_W; i++) begin
      k[BYTE_W-1-i] = t[LFSR_W-1];
      t = lfsr_next(t);
    end
    return k;
  endfunction
endpackage

// File: rtl/scr_seed.sv
module scr_seed
  import scr_pkg::*;
(
  input  logic [POS_W-1:0] pos_code,
  output lfsr_t            seed_state
);
  always_comb seed_state = lfsr_adv(LFSR_ONES, BYTE_W * int'(pos_code));
endmodule

// File: rtl/scr_gen.sv
module scr_gen
  import scr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  in_oh,
  input  logic  size_sel,
  input  lfsr_t seed_state,
  output lfsr_t cur_state,
  output lfsr_t gen_state
);
  lfsr_t jumped [2];
  lfsr_t next_state;

  assign cur_state = frame_start ? seed_state : gen_state;

  for (genvar g = 0; g < 2; g++) begin : g_jump
    localparam int STEPS = BYTE_W * ((g == 1) ? LARGE_IL : SMALL_IL);
    assign jumped[g] = lfsr_adv(cur_state, STEPS);
  end

  assign next_state = in_oh ? cur_state : jumped[size_sel];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gen_state <= LFSR_ONES;
    else        gen_state <= next_state;
endmodule

// File: rtl/scr_mix.sv
module scr_mix
  import scr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  scr_en_n,
  input  logic  in_oh,
  input  lfsr_t cur_state,
  input  byte_t din,
  output byte_t dout
);
  byte_t key_sel;

  assign key_sel = (!scr_en_n && !in_oh) ? key_of(cur_state) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dout <= '0;
    else        dout <= din ^ key_sel;
endmodule

// File: rtl/fsync_slice_scrambler.sv
module fsync_slice_scrambler
  import scr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scr_en_n,
  input  logic       frame_start,
  input  logic       in_oh,
  input  logic       size_sel,
  input  logic [2:0] pos_code,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  lfsr_t seed_state;
  lfsr_t cur_state;
  lfsr_t gen_state;

  scr_seed u_seed (
    .pos_code   (pos_code),
    .seed_state (seed_state)
  );

  scr_gen u_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .in_oh       (in_oh),
    .size_sel    (size_sel),
    .seed_state  (seed_state),
    .cur_state   (cur_state),
    .gen_state   (gen_state)
  );

  scr_mix u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .scr_en_n  (scr_en_n),
    .in_oh     (in_oh),
    .cur_state (cur_state),
    .din       (din),
    .dout      (dout)
  );
endmodule

// File: rtl/scr_checker.sv
module scr_checker
  import scr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scr_en_n,
  input logic       frame_start,
  input logic       in_oh,
  input logic [7:0] din,
  input logic [7:0] dout,
  input lfsr_t      gen_state,
  input lfsr_t      seed_state
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(scr_en_n) |-> dout == $past(din));

  // R6
  oh_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_oh) |-> dout == $past(din));

  // R6
  oh_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(in_oh) && !$past(frame_start) |-> gen_state == $past(gen_state));

  // R4
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(frame_start) && $past(in_oh) |-> gen_state == $past(seed_state));

  // R3
  state_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_state != '0);
endmodule

bind fsync_slice_scrambler scr_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scr_en_n    (scr_en_n),
  .frame_start (frame_start),
  .in_oh       (in_oh),
  .din         (din),
  .dout        (dout),
  .gen_state   (gen_state),
  .seed_state  (seed_state)
);

// File: tb/tb_fsync_slice_scrambler.sv
module tb_fsync_slice_scrambler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scr_en_n = 1'b1;
  logic       frame_start = 1'b0;
  logic       in_oh = 1'b0;
  logic       size_sel = 1'b0;
  logic [2:0] pos_code = 3'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit seq [0:1023];

  always #4 clk = ~clk;

  fsync_slice_scrambler dut (
    .clk(clk), .rst_n(rst_n), .scr_en_n(scr_en_n), .frame_start(frame_start),
    .in_oh(in_oh), .size_sel(size_sel), .pos_code(pos_code), .din(din), .dout(dout)
  );

  // vector: {size, pos[2:0], oh_mask[11:0], dis_mask[11:0]}
  localparam int NV = 9;
  localparam int NS = 12;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 3'd0, 12'h000, 12'h000},
    {1'b0, 3'd1, 12'h000, 12'h000},
    {1'b1, 3'd0, 12'h000, 12'h000},
    {1'b1, 3'd7, 12'h000, 12'h000},
    {1'b1, 3'd3, 12'h007, 12'h000},
    {1'b0, 3'd1, 12'h0C5, 12'h000},
    {1'b1, 3'd5, 12'h000, 12'h038},
    {1'b0, 3'd0, 12'h003, 12'hC00},
    {1'b1, 3'd2, 12'h0F0, 12'h001}
  };

  function automatic logic [7:0] keyb(input int idx);
    logic [7:0] k;
    for (int i = 0; i < 8; i++) k[7-i] = seq[idx*8 + i];
    return k;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic drive(input bit fs, input bit oh, input bit dis, input logic [7:0] d);
    @(negedge clk);
    frame_start = fs; in_oh = oh; scr_en_n = dis; din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: dout=%02h expected=done", dout);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 1024; n++)
      seq[n] = (n < 7) ? 1'b1 : (seq[n-6] ^ seq[n-7]);

    // R1: reset state
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", dout, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1 after release", dout, 8'h00);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      int nn;
      int pp;
      int live;
      nn = VEC[v][27] ? 8 : 2;
      pp = int'(VEC[v][26:24]);
      size_sel = VEC[v][27];
      pos_code = VEC[v][26:24];
      live = 0;
      for (int m = 0; m < NS; m++) begin
        logic [7:0] d;
        logic [7:0] exp;
        bit oh;
        bit dis;
        oh  = VEC[v][12+m];
        dis = VEC[v][m];
        d = 8'(m*37 + pp*11 + v*5 + 3);
        drive(m == 0, oh, dis, d);
        if (oh) begin
          chk("R6 overhead byte", dout, d);
        end else begin
          exp = dis ? d : d ^ keyb(live*nn + pp);
          if (dis)            chk("R2 disabled byte", dout, exp);
          else if (v >= 6)    chk("R8 resume in phase", dout, exp);
          else if (v >= 4)    chk("R6 after overhead", dout, exp);
          else if (m == 0)    chk("R4 frame seed", dout, exp);
          else if (nn == 8)   chk("R5 64-way slice", dout, exp);
          else                chk("R7 interleaved line", dout, exp);
          live++;
        end
      end
    end

    // R4: frame restart mid-stream, position 1 of 16-way
    size_sel = 1'b0; pos_code = 3'd1;
    drive(1, 0, 0, 8'h11);
    chk("R4 first frame", dout, 8'h11 ^ keyb(1));
    drive(0, 0, 0, 8'h22);
    chk("R3 second byte", dout, 8'h22 ^ keyb(3));
    drive(1, 0, 0, 8'h33);
    chk("R4 restart", dout, 8'h33 ^ keyb(1));
    drive(0, 0, 0, 8'h44);
    chk("R5 16-way step", dout, 8'h44 ^ keyb(3));

    // R6: overhead with frame_start, then first payload uses seed key
    drive(1, 1, 0, 8'h5A);
    chk("R6 oh on frame start", dout, 8'h5A);
    drive(0, 0, 0, 8'hA5);
    chk("R6 seed kept", dout, 8'hA5 ^ keyb(1));

    // R1: reset during traffic
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 async reset", dout, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule